// File: doc/BRIEF.md
# Converter Sync and Data-Ready Sequencer

This block is the digital timing control of a multichannel delta-sigma converter. It divides the master clock into conversion periods. The length of a period is chosen by a two-bit mode input. The block emits one conversion strobe per period, and this strobe is shared by every channel. It also holds the decimation filter's counters in reset while the active-low synchronization pin is low, or for one clock when the mode changes. After either event it counts conversion strobes until the filter has settled.

Valid data are shown in one of two formats. In the SPI-style format a data-ready line stays high through the whole settling count. Once settled, it pulses low after each strobe. In the frame-sync format a force-low control clamps the serial data line until settling is complete. A clock-loss input clamps it again, and the clamp holds until a fresh sync pulse has been given and settling has run again.

Top module: `conv_sync_seq`

## Requirements
- R1: While rst_ni is low, conv_stb_o is 0, drdy_o is 1 and filt_rst_o is 1. dout_force_low_o is 1 exactly when fmt_fs_i is 1.
- R2: Mode codes 0, 1, 2 and 3 select a conversion period of 8, 16, 32 and 64 master clocks. conv_stb_o is high for one clock per period. The first strobe comes in the period-th clock after filt_rst_o falls, counting the first clock with filt_rst_o low as clock 1.
- R3: Within two clocks of sync_ni going low, filt_rst_o and drdy_o are high and conv_stb_o is low. In frame-sync format dout_force_low_o is also high. All of these hold for as long as sync_ni stays low.
- R4: After filt_rst_o falls, drdy_o stays high until the 128th conversion strobe. It goes low in the clock after that strobe.
- R5: Once settled, drdy_o is low for the first (period − 2) clocks after each strobe. It is high for the last 2 clocks of each period, including the clock of the strobe itself.
- R6: When fmt_fs_i is 1, dout_force_low_o stays high until the 128th strobe after filt_rst_o falls, and goes low in the next clock. When fmt_fs_i is 0, dout_force_low_o is always 0.
- R7: A change on mode_i raises filt_rst_o and drdy_o in the same clock. The new period starts, and settling restarts from zero.
- R8: In frame-sync format, a clk_loss_i pulse raises dout_force_low_o from the next clock. It stays high, through any number of strobes, until sync_ni has been low and settling has completed again. In SPI format clk_loss_i has no effect on drdy_o.
- R9: Instances that share the master clock, sync_ni and mode_i produce conv_stb_o and filt_rst_o in the same clock cycles, whatever their format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Asynchronous synchronization pin, active low |
| mode_i | input | 2 | Mode code that selects the conversion period |
| fmt_fs_i | input | 1 | 1 = frame-sync format, 0 = SPI-style format |
| clk_loss_i | input | 1 | Pulse that flags an interrupted serial or frame clock |
| conv_stb_o | output | 1 | One-clock conversion strobe |
| drdy_o | output | 1 | Data ready, active low |
| dout_force_low_o | output | 1 | Clamps the serial data line low |
| filt_rst_o | output | 1 | Holds the decimation filter counters in reset |

## Verification
A wrong period counter shows up at the first strobe after a restart, as a strobe that comes early, comes late or is missing. A wrong settling count shifts the first low drdy_o or the release of dout_force_low_o by at least one whole period, and this is visible about 128 periods after the restart. A valid or lost flag that fails to clear stays visible on dout_force_low_o for a full settling interval. The bench therefore compares every clock against a model of the phase within the period and the count of strobes, sweeping all four modes.

// File: rtl/css_pkg.sv
package css_pkg;
  typedef enum logic {FMT_SPI = 1'b0, FMT_FS = 1'b1} fmt_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/css_sync_in.sv
module css_sync_in #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[i] <= 1'b0;
      else if (i == 0) ff_q[i] <= pin_i;
      else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
    end
  end

  assign lvl_o = ff_q[STAGES-1];
endmodule

// File: rtl/css_timer.sv
module css_timer #(
  parameter int unsigned DIV_TAB [4] = '{8, 16, 32, 64},
  parameter int unsigned DRDY_HI = 2,
  parameter int unsigned CNT_W   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] mode_i,
  output logic       stb_o,
  output logic       raise_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c, raise_at_c;

  assign last_c     = CNT_W'(DIV_TAB[mode_i] - 1);
  assign raise_at_c = CNT_W'(DIV_TAB[mode_i] - 1 - DRDY_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (cnt_q == last_c)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o   = !restart_i && (cnt_q == last_c);
  assign raise_o = !restart_i && (cnt_q == raise_at_c);
endmodule

// File: rtl/css_settle.sv
module css_settle
  import css_pkg::*;
#(
  parameter int unsigned SPI_T = 128,
  parameter int unsigned FS_T  = 128,
  localparam int unsigned SW   = $clog2(max2(SPI_T, FS_T) + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic stb_i,
  input  fmt_e fmt_i,
  output logic complete_o,
  output logic done_o
);
  logic [SW-1:0] cnt_q;
  logic [SW-1:0] last_c;
  logic          done_q;

  assign last_c     = (fmt_i == FMT_FS) ? SW'(FS_T - 1) : SW'(SPI_T - 1);
  assign complete_o = stb_i && !done_q && (cnt_q == last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (stb_i && !done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= complete_o;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/css_ready.sv
module css_ready
  import css_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic sync_lvl_i,
  input  logic stb_i,
  input  logic complete_i,
  input  logic done_i,
  input  logic raise_i,
  input  fmt_e fmt_i,
  input  logic clk_loss_i,
  output logic drdy_o,
  output logic dout_force_low_o
);
  logic drdy_q, lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            drdy_q <= 1'b1;
    else if (restart_i)                     drdy_q <= 1'b1;
    else if (stb_i && (done_i || complete_i)) drdy_q <= 1'b0;
    else if (raise_i)                       drdy_q <= 1'b1;
  end

  // lost clock needs a fresh sync pulse to clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lost_q <= 1'b0;
    else if (!sync_lvl_i) lost_q <= 1'b0;
    else if (clk_loss_i)  lost_q <= 1'b1;
  end

  assign drdy_o           = drdy_q | restart_i;
  assign dout_force_low_o = (fmt_i == FMT_FS) && (restart_i || !done_i || lost_q);
endmodule

// File: rtl/conv_sync_seq.sv
module conv_sync_seq
  import css_pkg::*;
#(
  parameter int unsigned DIV_TAB [4] = '{8, 16, 32, 64},
  parameter int unsigned DRDY_HI     = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SETTLE_SPI  = 128,
  parameter int unsigned SETTLE_FS   = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_ni,
  input  logic [1:0] mode_i,
  input  logic       fmt_fs_i,
  input  logic       clk_loss_i,
  output logic       conv_stb_o,
  output logic       drdy_o,
  output logic       dout_force_low_o,
  output logic       filt_rst_o
);
  logic       sync_lvl, restart, stb, raise, complete, done;
  logic [1:0] mode_q;
  fmt_e       fmt;

  assign fmt = fmt_e'(fmt_fs_i);

  css_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(sync_ni), .lvl_o(sync_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 2'd0;
    else         mode_q <= mode_i;
  end

  // mode change acts as a one-clock sync event
  assign restart = !sync_lvl || (mode_i != mode_q);

  css_timer #(.DIV_TAB(DIV_TAB), .DRDY_HI(DRDY_HI), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart), .mode_i(mode_q),
    .stb_o(stb), .raise_o(raise)
  );

  css_settle #(.SPI_T(SETTLE_SPI), .FS_T(SETTLE_FS)) u_settle (
    .clk_i, .rst_ni, .restart_i(restart), .stb_i(stb), .fmt_i(fmt),
    .complete_o(complete), .done_o(done)
  );

  css_ready u_ready (
    .clk_i, .rst_ni, .restart_i(restart), .sync_lvl_i(sync_lvl),
    .stb_i(stb), .complete_i(complete), .done_i(done), .raise_i(raise),
    .fmt_i(fmt), .clk_loss_i, .drdy_o, .dout_force_low_o
  );

  assign conv_stb_o = stb;
  assign filt_rst_o = restart;
endmodule

// File: rtl/conv_sync_seq_chk.sv
module conv_sync_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_ni,
  input logic [1:0] mode_i,
  input logic       fmt_fs_i,
  input logic       clk_loss_i,
  input logic       conv_stb_o,
  input logic       drdy_o,
  input logic       dout_force_low_o,
  input logic       filt_rst_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2
  stb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_stb_o |=> !conv_stb_o);

  // R3
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sync_ni, 2) |-> (filt_rst_o && drdy_o && !conv_stb_o));

  // R5
  drdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_o) |-> $past(conv_stb_o));

  // R6
  dout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dout_force_low_o) |-> $past(conv_stb_o));

  // R7
  mode_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mode_i != $past(mode_i)) |-> (filt_rst_o && drdy_o));

  // R7
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_o |=> !conv_stb_o);

  // R8
  loss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_loss_i && fmt_fs_i) |=> dout_force_low_o);
endmodule

bind conv_sync_seq conv_sync_seq_chk u_chk (
  .clk_i, .rst_ni, .sync_ni, .mode_i, .fmt_fs_i, .clk_loss_i,
  .conv_stb_o, .drdy_o, .dout_force_low_o, .filt_rst_o
);

// File: tb/test_conv_sync_seq.sv
`timescale 1ns/1ps
module test_conv_sync_seq;
  localparam int H = 2;
  localparam int T = 128;
  localparam int DIVS [4] = '{8, 16, 32, 64};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sync_n, fmt_a, clk_loss;
  logic [1:0] mode;
  logic a_stb, a_drdy, a_dfl, a_frst;
  logic b_stb, b_drdy, b_dfl, b_frst;

  int errs = 0, checks = 0;
  int since, prior;
  bit lost_b;
  bit finished = 1'b0;

  conv_sync_seq i_conv_sync_seq (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .mode_i(mode),
    .fmt_fs_i(fmt_a), .clk_loss_i(clk_loss), .conv_stb_o(a_stb),
    .drdy_o(a_drdy), .dout_force_low_o(a_dfl), .filt_rst_o(a_frst)
  );

  conv_sync_seq i_conv_sync_seq_b (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .mode_i(mode),
    .fmt_fs_i(1'b1), .clk_loss_i(clk_loss), .conv_stb_o(b_stb),
    .drdy_o(b_drdy), .dout_force_low_o(b_dfl), .filt_rst_o(b_frst)
  );

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one sampled clock against the phase / strobe-count model
  task automatic step(int div);
    int exp_drdy;
    chk_eq("R2 strobe", a_stb, int'(since == div));
    chk_eq("R9 strobe align", b_stb, a_stb);
    chk_eq("R9 reset align", b_frst, a_frst);
    exp_drdy = (prior < T) ? 1 : ((since <= div - H) ? 0 : 1);
    chk_eq((prior < T) ? "R4 drdy settling" : "R5 drdy steady", a_drdy, exp_drdy);
    chk_eq(lost_b ? "R8 clamp after loss" : "R6 fs clamp", b_dfl, int'((prior < T) || lost_b));
    chk_eq("R6 spi no clamp", a_dfl, 0);
    if (since == div) begin since = 1; prior++; end
    else since++;
    @(negedge clk);
  endtask

  task automatic watch(int div, int n, bit fresh);
    if (fresh) begin
      for (int i = 0; i < 8; i++) begin
        if (!a_frst) break;
        @(negedge clk);
      end
      since = 1;
      prior = 0;
    end
    repeat (n) step(div);
  endtask

  initial begin
    #(8ns * 190000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_n = 1'b1; mode = 2'd0; fmt_a = 1'b0; clk_loss = 1'b0;
    lost_b = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk_eq("R1 stb", a_stb, 0);
      chk_eq("R1 drdy", a_drdy, 1);
      chk_eq("R1 filt", a_frst, 1);
      chk_eq("R1 spi dout", a_dfl, 0);
      chk_eq("R1 fs dout", b_dfl, 1);
    end
    rst_n = 1'b1;
    watch(DIVS[0], T * DIVS[0] + 40, 1'b1);

    // R8: clock loss pulse
    clk_loss = 1'b1;
    step(DIVS[0]);
    clk_loss = 1'b0;
    lost_b = 1'b1;
    watch(DIVS[0], 5 * DIVS[0], 1'b0);

    // R3: sync pulse
    sync_n = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      chk_eq("R3 filt", a_frst, 1);
      chk_eq("R3 drdy", a_drdy, 1);
      chk_eq("R3 stb", a_stb, 0);
      chk_eq("R3 fs dout", b_dfl, 1);
      @(negedge clk);
    end
    sync_n = 1'b1;
    lost_b = 1'b0;
    watch(DIVS[0], T * DIVS[0] + 40, 1'b1);

    // R7: sweep the remaining modes
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      #1;
      chk_eq("R7 filt", a_frst, 1);
      chk_eq("R7 drdy", a_drdy, 1);
      @(negedge clk);
      watch(DIVS[m], (T + 3) * DIVS[m], 1'b1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule